// File: doc/BRIEF.md
# Eight-lane sliding sum-of-absolute-differences engine

The engine compares a four-byte reference block against eight overlapping positions of a byte window and reports one sum of absolute differences for each position. Both operands are 128-bit words of sixteen unsigned bytes. Byte n of an operand sits in bits [8n+7:8n]. A small control field picks where the window starts in the first operand and where the reference block starts in the second operand. A motion-search datapath can then score eight candidate alignments in one pass.

An operand pair enters on a cycle with `in_valid` high. The first pipeline stage registers all thirty-two absolute differences. The second stage adds them in groups of four. The eight 16-bit sums appear together with `out_valid` after exactly two clock edges. A new operand pair may enter on every cycle.

Top module: `sad8_engine`

## Requirements
- R1: Control bit 2 selects the window start in `op_a`: byte 0 when it is 0, byte 4 when it is 1.
- R2: Control bits [1:0], taken as an unsigned value s, place the reference block at bytes 4s to 4s+3 of `op_b`.
- R3: With window start i and reference start j, lane k (k = 0..7) of the result is the sum over m = 0..3 of |a[i+k+m] - b[j+m]|. Lane k occupies bits [16k+15:16k] of `out_sums`.
- R4: All bytes are unsigned. A difference between 0x00 and 0xFF counts as 255.
- R5: Control bits 7 down to 3 have no effect on the result.
- R6: `out_valid` is high after the second rising clock edge following a cycle with `in_valid` high, and only then. Back-to-back inputs give back-to-back results in the same order.
- R7: While reset is held, `out_valid` is 0 and `out_sums` is 0. After that, `out_sums` keeps its value on any cycle without a new result.
- R8: Every lane stays at or below 1020, so bits 15:10 of each lane are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and control are valid this cycle |
| op_a | input | 128 | Window operand, sixteen unsigned bytes |
| op_b | input | 128 | Reference operand, sixteen unsigned bytes |
| ctrl | input | 8 | Bit 2 selects the window start, bits 1:0 select the reference block, bits 7:3 are ignored |
| out_valid | output | 1 | Result valid strobe |
| out_sums | output | 128 | Eight 16-bit sums, lane 0 in the low bits |

## Verification
The bench sweeps all 256 control values. A design that decodes the wrong control bit, or lets bits 7:3 leak into the offsets, would produce lane sums that match a shifted window or reference block instead of the one selected. Ramp operands give known sum patterns. Under these patterns a reversed lane order or an off-by-one window shows up as a reversed or shifted sequence of sums.

Operands of all 0x00 against all 0xFF catch signed handling of the bytes, which would report 4 instead of 1020, and also catch a truncated adder. A stream of back-to-back operand pairs, followed by idle cycles with changing inputs, exposes three faults: a stage that drops or repeats a result, a valid strobe one cycle early or late, and outputs that follow the inputs while no result is due.

// File: rtl/sad8_engine.sv
module sad8_engine #(
  parameter int DW    = 8,
  parameter int SW    = 16,
  parameter int CW    = 8,
  parameter int LANES = 8,
  parameter int TAPS  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [16*DW-1:0]    op_a,
  input  logic [16*DW-1:0]    op_b,
  input  logic [CW-1:0]       ctrl,
  output logic                out_valid,
  output logic [LANES*SW-1:0] out_sums
);
  localparam int WIN = LANES + TAPS - 1;

  logic [DW-1:0] win  [WIN];
  logic [DW-1:0] refb [TAPS];
  logic [DW-1:0] ad_d [LANES][TAPS];
  logic [DW-1:0] ad_q [LANES][TAPS];
  logic [SW-1:0] sum_d [LANES];
  logic          v1;
  logic          unused_hi;

  assign unused_hi = ^ctrl[CW-1:3];

  for (genvar w = 0; w < WIN; w++) begin : g_win
    assign win[w] = ctrl[2] ? op_a[(w+TAPS)*DW +: DW] : op_a[w*DW +: DW];
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_ref
    assign refb[t] = op_b[(int'(ctrl[1:0])*TAPS + t)*DW +: DW];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar m = 0; m < TAPS; m++) begin : g_tap
      assign ad_d[k][m] = (win[k+m] > refb[m]) ? win[k+m] - refb[m]
                                               : refb[m] - win[k+m];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      for (int k = 0; k < LANES; k++)
        for (int m = 0; m < TAPS; m++)
          ad_q[k][m] <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) ad_q <= ad_d;
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      sum_d[k] = '0;
      for (int m = 0; m < TAPS; m++)
        sum_d[k] = sum_d[k] + SW'(ad_q[k][m]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sums  <= '0;
    end else begin
      out_valid <= v1;
      if (v1)
        for (int k = 0; k < LANES; k++)
          out_sums[k*SW +: SW] <= sum_d[k];
    end
  end
endmodule

module sad8_engine_chk #(
  parameter int DW    = 8,
  parameter int SW    = 16,
  parameter int CW    = 8,
  parameter int LANES = 8,
  parameter int TAPS  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [16*DW-1:0]    op_a,
  input logic [16*DW-1:0]    op_b,
  input logic [CW-1:0]       ctrl,
  input logic                out_valid,
  input logic [LANES*SW-1:0] out_sums
);
  localparam int MAXSUM = TAPS * ((1 << DW) - 1);

  logic c1, c2, in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c1 <= 1'b0;
      c2 <= 1'b0;
    end else begin
      c1 <= in_valid;
      c2 <= c1;
    end
  end

  always_comb begin
    in_range = 1'b1;
    for (int k = 0; k < LANES; k++)
      if (int'(out_sums[k*SW +: SW]) > MAXSUM) in_range = 1'b0;
  end

  // R6
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == c2);

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sums));

  // R8
  sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_range);

  // R3
  zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl[2:0] == 3'b000 && op_a[TAPS*DW-1:0] == op_b[TAPS*DW-1:0])
    |=> ##1 (out_sums[SW-1:0] == '0));

  // R1
  window_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctrl[2:0] == 3'b101 &&
     op_a[2*TAPS*DW-1:TAPS*DW] == op_b[2*TAPS*DW-1:TAPS*DW])
    |=> ##1 (out_sums[SW-1:0] == '0));
endmodule

bind sad8_engine sad8_engine_chk #(
  .DW(DW), .SW(SW), .CW(CW), .LANES(LANES), .TAPS(TAPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .ctrl(ctrl), .out_valid(out_valid), .out_sums(out_sums)
);

// File: tb/test_sad8_engine.sv
module test_sad8_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0;
  logic [127:0] op_b = '0;
  logic [7:0]   ctrl = '0;
  logic         out_valid;
  logic [127:0] out_sums;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sad8_engine i_sad8_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .ctrl(ctrl), .out_valid(out_valid), .out_sums(out_sums)
  );

  function automatic logic [127:0] model(input logic [127:0] a,
                                         input logic [127:0] b,
                                         input logic [7:0] c);
    logic [127:0] r = '0;
    int i = c[2] ? 4 : 0;
    int j = 4 * int'(c[1:0]);
    for (int k = 0; k < 8; k++) begin
      int s = 0;
      for (int m = 0; m < 4; m++) begin
        int x = int'(a[8*(i+k+m) +: 8]);
        int y = int'(b[8*(j+m) +: 8]);
        s += (x > y) ? x - y : y - x;
      end
      r[16*k +: 16] = 16'(s);
    end
    return r;
  endfunction

  function automatic logic [127:0] pack8(input int v [8]);
    logic [127:0] r = '0;
    for (int k = 0; k < 8; k++) r[16*k +: 16] = 16'(v[k]);
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(input string req, input logic [127:0] a,
                         input logic [127:0] b, input logic [7:0] c,
                         input logic [127:0] exp);
    @(negedge clk);
    op_a = a; op_b = b; ctrl = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 early", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    check("R6 valid", {127'd0, out_valid}, 128'd1);
    check(req, out_sums, exp);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] ramp;
    logic [127:0] hold;
    logic [127:0] sa [10];
    logic [127:0] sb [10];
    logic [7:0]   sc [10];
    for (int n = 0; n < 16; n++) ramp[8*n +: 8] = 8'(n);

    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 reset valid", {127'd0, out_valid}, 128'd0);
    check("R7 reset sums", out_sums, 128'd0);
    rst_n = 1'b1;

    // R3 known ramp results, R1 and R2 offsets
    run_one("R3 ramp c0", ramp, ramp, 8'b000, pack8('{0,4,8,12,16,20,24,28}));
    run_one("R2 ramp c1", ramp, ramp, 8'b001, pack8('{16,12,8,4,0,4,8,12}));
    run_one("R1 ramp c4", ramp, ramp, 8'b100, pack8('{16,20,24,28,32,36,40,44}));
    run_one("R1 R2 ramp c7", ramp, ramp, 8'b111, pack8('{32,28,24,20,16,12,8,4}));

    // R4 and R8 unsigned extremes
    run_one("R4 R8 ff vs 00", {16{8'hFF}}, {16{8'h00}}, 8'b010, {8{16'd1020}});
    run_one("R4 R8 00 vs ff", {16{8'h00}}, {16{8'hFF}}, 8'b101, {8{16'd1020}});
    run_one("R4 80 vs 7f", {16{8'h80}}, {16{8'h7F}}, 8'b011, {8{16'd4}});

    // R1 R2 R3 R5 sweep of every control value
    for (int c = 0; c < 256; c++) begin
      logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
      run_one("R5 R3 ctrl sweep", a, b, 8'(c), model(a, b, {5'd0, 3'(c)}));
    end

    // R6 back-to-back stream
    for (int n = 0; n < 10; n++) begin
      sa[n] = {$urandom, $urandom, $urandom, $urandom};
      sb[n] = {$urandom, $urandom, $urandom, $urandom};
      sc[n] = 8'($urandom);
    end
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (c >= 2) begin
        check("R6 stream valid", {127'd0, out_valid}, 128'd1);
        check("R6 stream data", out_sums, model(sa[c-2], sb[c-2], sc[c-2]));
      end
      if (c < 10) begin
        op_a = sa[c]; op_b = sb[c]; ctrl = sc[c]; in_valid = 1'b1;
      end else in_valid = 1'b0;
    end

    // R7 hold while idle with changing inputs
    hold = out_sums;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      op_a = ~op_a; op_b = op_b + 128'd3; ctrl = ctrl + 8'd1;
      check("R7 idle valid", {127'd0, out_valid}, 128'd0);
      check("R7 idle hold", out_sums, hold);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule